// File: doc/BRIEF.md
# Late-Drive Read Data Responder

This block answers read cycles on an 8-bit bus that is clocked by a phase signal, PHI0. A capture sequencer elsewhere decodes the address and pulses `trigger` once per read cycle. The responder then samples the active-low device-select input. If that input is high, the cycle belongs to another device and the responder stays idle. If it is low, the responder raises `busy` and walks through a fixed timeline. Every point on that timeline is counted in system clocks from the synchronized PHI0 rising edge.

The timeline has four steps, in this order:
- the data transceiver is turned to the output direction;
- the data pins are switched to outputs;
- the response byte is fetched from a show-ahead queue, without waiting for it;
- that byte is placed on the pins.

All of this happens as late in the phase as the parameters allow. After PHI0 falls, the byte is held on the bus for a short fixed number of clocks. The block then disables the transceiver, releases the pins and clears its output register. If the queue is empty at the fetch point, the block drives all ones and raises an underrun flag.

Transceiver control uses a 2-bit code: `01` means enabled in the output direction, and `10` means disabled, with the bus tri-stated.

Timing convention: E1 is the first clock edge that samples PHI0 high. A timeline point of T clocks takes effect on edge E(T+3). This accounts for two synchronizer stages, one edge-detect register and the registered output. The pop request `q_pop` is combinational and is high in the cycle before that edge.

Top module: `late_read_driver`

## Requirements
- R1: After reset, the outputs are: `xcvr_ctl` = `10`, `pins_oe` = 0, `data_out` = 0, `busy` = 0, `underrun` = 0 and `q_pop` = 0.
- R2: A `trigger` sampled with `dev_sel_n` = 1 is ignored. `busy`, `xcvr_ctl`, `pins_oe`, `data_out` and `underrun` keep their values, and the queue is not popped.
- R3: A `trigger` sampled with `dev_sel_n` = 0 while idle sets `busy` on that same edge and clears `underrun`.
- R4: On edge E(T_XCVR+3), `xcvr_ctl` becomes `01` and `data_out` becomes all ones. `busy` is high whenever `xcvr_ctl` is `01`.
- R5: On edge E(T_OE+3), `pins_oe` becomes 1. `pins_oe` is never 1 unless `xcvr_ctl` is `01`.
- R6: If the queue is not empty, `q_pop` is high for exactly one cycle, ending at edge E(T_FETCH+3), and `q_data` is captured on that edge.
- R7: On edge E(T_DRIVE+3), `data_out` takes the captured byte.
- R8: If `q_empty` = 1 at the fetch point, there is no pop. `underrun` is set on E(T_FETCH+3), and `data_out` stays all ones after E(T_DRIVE+3).
- R9: Let F1 be the first edge that samples PHI0 low. The driven state holds until edge F(HOLD_CYC+4). On that edge `xcvr_ctl` becomes `10`, and `pins_oe`, `data_out` and `busy` all become 0. `underrun` keeps its value.
- R10: A `trigger` that arrives while a response is in progress, including on the release edge itself, is ignored. `busy` stays low after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi0 | input | 1 | Raw bus phase clock (asynchronous) |
| trigger | input | 1 | One-cycle pulse from the capture sequencer |
| dev_sel_n | input | 1 | Active-low device select, valid together with trigger |
| q_empty | input | 1 | Response queue is empty |
| q_data | input | DATA_W | Head byte of the show-ahead response queue |
| q_pop | output | 1 | Consume the head entry of the queue |
| busy | output | 1 | A response is in progress |
| xcvr_ctl | output | 2 | Transceiver control: 01 = output direction, 10 = disabled |
| pins_oe | output | 1 | Data pins are driven as outputs |
| data_out | output | DATA_W | Output register value presented on the pins |
| underrun | output | 1 | The queue was empty at the last fetch point |

## Verification
Two events can land on the same clock edge: the release at the end of the hold window, and a new trigger that is still addressed to this device. The bench times a trigger pulse so that it is sampled on exactly the release edge. It then expects `busy` to stay low on every following cycle, with the transceiver disabled and the pins released. Each phase is also checked cycle by cycle against the edge formulas in the requirements. The sweep covers addressed and unaddressed cycles, empty and non-empty queues, and a range of byte values.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
  localparam logic [1:0] XCVR_OUT = 2'b01;
  localparam logic [1:0] XCVR_OFF = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_PREP,
    ST_FETCH,
    ST_DRIVE,
    ST_WAITFALL,
    ST_HOLD
  } lrd_state_e;
endpackage

// File: rtl/lrd_rst_sync.sv
module lrd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_sync_n = chain_q[1];
endmodule

// File: rtl/lrd_phase_timer.sv
module lrd_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phi0_raw,
  output logic             phi_hi,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic sync1_q, sync2_q, dly_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic rise;

  // Two synchronizer stages followed by one delay stage for edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      dly_q   <= 1'b0;
    end else begin
      sync1_q <= phi0_raw;
      sync2_q <= sync1_q;
      dly_q   <= sync2_q;
    end
  end

  assign rise = sync2_q & ~dly_q;

  always_comb begin
    if (rise)                cnt_d = CNT_W'(1);
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_MAX;
    else        cnt_q <= cnt_d;
  end

  assign phi_hi = sync2_q;
  assign cnt    = cnt_q;
endmodule

// File: rtl/lrd_seq.sv
module lrd_seq
  import lrd_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int T_XCVR   = 40,
  parameter int T_OE     = 104,
  parameter int T_FETCH  = 105,
  parameter int T_DRIVE  = 106,
  parameter int HOLD_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigger,
  input  logic             dev_sel_n,
  input  logic             phi_hi,
  input  logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic [1:0]       xcvr_ctl,
  output logic             pins_oe,
  output logic             step_accept,
  output logic             step_ones,
  output logic             step_fetch,
  output logic             step_drive,
  output logic             step_release
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 2);
  localparam logic [CNT_W-1:0]  TX_C = CNT_W'(T_XCVR);
  localparam logic [CNT_W-1:0]  TO_C = CNT_W'(T_OE);
  localparam logic [CNT_W-1:0]  TF_C = CNT_W'(T_FETCH);
  localparam logic [CNT_W-1:0]  TD_C = CNT_W'(T_DRIVE);
  localparam logic [HOLD_W-1:0] TH_C = HOLD_W'(HOLD_CYC);

  lrd_state_e        state_q, state_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              busy_q, busy_d, oe_q, oe_d;
  logic [1:0]        xcvr_q, xcvr_d;

  always_comb begin
    state_d      = state_q;
    hold_d       = hold_q;
    busy_d       = busy_q;
    oe_d         = oe_q;
    xcvr_d       = xcvr_q;
    step_accept  = 1'b0;
    step_ones    = 1'b0;
    step_fetch   = 1'b0;
    step_drive   = 1'b0;
    step_release = 1'b0;
    unique case (state_q)
      ST_IDLE: if (trigger && !dev_sel_n) begin
        state_d     = ST_ARM;
        busy_d      = 1'b1;
        step_accept = 1'b1;
      end
      ST_ARM: if (cnt >= TX_C) begin
        state_d   = ST_PREP;
        xcvr_d    = XCVR_OUT;
        step_ones = 1'b1;
      end
      ST_PREP: if (cnt >= TO_C) begin
        state_d = ST_FETCH;
        oe_d    = 1'b1;
      end
      ST_FETCH: if (cnt >= TF_C) begin
        state_d    = ST_DRIVE;
        step_fetch = 1'b1;
      end
      ST_DRIVE: if (cnt >= TD_C) begin
        state_d    = ST_WAITFALL;
        step_drive = 1'b1;
      end
      ST_WAITFALL: if (!phi_hi) begin
        state_d = ST_HOLD;
        hold_d  = '0;
      end
      ST_HOLD: begin
        if (hold_q == TH_C) begin
          state_d      = ST_IDLE;
          busy_d       = 1'b0;
          oe_d         = 1'b0;
          xcvr_d       = XCVR_OFF;
          step_release = 1'b1;
        end else begin
          hold_d = hold_q + HOLD_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      busy_q  <= 1'b0;
      oe_q    <= 1'b0;
      xcvr_q  <= XCVR_OFF;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      busy_q  <= busy_d;
      oe_q    <= oe_d;
      xcvr_q  <= xcvr_d;
    end
  end

  assign busy     = busy_q;
  assign pins_oe  = oe_q;
  assign xcvr_ctl = xcvr_q;
endmodule

// File: rtl/lrd_out_stage.sv
module lrd_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_accept,
  input  logic              step_ones,
  input  logic              step_fetch,
  input  logic              step_drive,
  input  logic              step_release,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_data,
  output logic              q_pop,
  output logic [DATA_W-1:0] data_out,
  output logic              underrun
);
  logic [DATA_W-1:0] out_q, out_d, stage_q, stage_d;
  logic              ur_q, ur_d;
  logic              stage_en;

  assign stage_en = step_fetch;
  assign q_pop    = step_fetch & ~q_empty;

  always_comb begin
    out_d = out_q;
    if (step_release)    out_d = '0;
    else if (step_ones)  out_d = '1;
    else if (step_drive) out_d = stage_q;

    stage_d = q_empty ? out_q : q_data;

    ur_d = ur_q;
    if (step_accept)     ur_d = 1'b0;
    else if (step_fetch) ur_d = q_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      stage_q <= '0;
      ur_q    <= 1'b0;
    end else begin
      out_q <= out_d;
      ur_q  <= ur_d;
      if (stage_en) stage_q <= stage_d;
    end
  end

  assign data_out = out_q;
  assign underrun = ur_q;
endmodule

// File: rtl/late_read_driver.sv
module late_read_driver #(
  parameter int DATA_W   = 8,
  parameter int T_XCVR   = 40,
  parameter int T_OE     = 104,
  parameter int T_FETCH  = 105,
  parameter int T_DRIVE  = 106,
  parameter int HOLD_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi0,
  input  logic              trigger,
  input  logic              dev_sel_n,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_data,
  output logic              q_pop,
  output logic              busy,
  output logic [1:0]        xcvr_ctl,
  output logic              pins_oe,
  output logic [DATA_W-1:0] data_out,
  output logic              underrun
);
  localparam int CNT_W = $clog2(T_DRIVE + 2);

  logic             rst_sync_n;
  logic             phi_hi;
  logic [CNT_W-1:0] cnt;
  logic             step_accept, step_ones, step_fetch, step_drive, step_release;

  lrd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lrd_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .phi0_raw (phi0),
    .phi_hi   (phi_hi),
    .cnt      (cnt)
  );

  lrd_seq #(
    .CNT_W    (CNT_W),
    .T_XCVR   (T_XCVR),
    .T_OE     (T_OE),
    .T_FETCH  (T_FETCH),
    .T_DRIVE  (T_DRIVE),
    .HOLD_CYC (HOLD_CYC)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .trigger      (trigger),
    .dev_sel_n    (dev_sel_n),
    .phi_hi       (phi_hi),
    .cnt          (cnt),
    .busy         (busy),
    .xcvr_ctl     (xcvr_ctl),
    .pins_oe      (pins_oe),
    .step_accept  (step_accept),
    .step_ones    (step_ones),
    .step_fetch   (step_fetch),
    .step_drive   (step_drive),
    .step_release (step_release)
  );

  lrd_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .step_accept  (step_accept),
    .step_ones    (step_ones),
    .step_fetch   (step_fetch),
    .step_drive   (step_drive),
    .step_release (step_release),
    .q_empty      (q_empty),
    .q_data       (q_data),
    .q_pop        (q_pop),
    .data_out     (data_out),
    .underrun     (underrun)
  );
endmodule

// File: rtl/late_read_driver_chk.sv
module late_read_driver_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trigger,
  input logic              dev_sel_n,
  input logic              q_empty,
  input logic              busy,
  input logic [1:0]        xcvr_ctl,
  input logic              pins_oe,
  input logic [DATA_W-1:0] data_out,
  input logic              underrun
);
  // R9: only the two legal transceiver codes ever appear
  p_xcvr_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_ctl == 2'b01) || (xcvr_ctl == 2'b10));

  // R5: pins are never driven through a disabled transceiver
  p_oe_needs_xcvr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pins_oe |-> (xcvr_ctl == 2'b01));

  // R4: an enabled transceiver only occurs during a response
  p_xcvr_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_ctl == 2'b01) |-> busy);

  // R3: a response starts only from an addressed trigger
  p_busy_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trigger && !dev_sel_n));

  // R9: the end of a response leaves the bus fully released
  p_release_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (xcvr_ctl == 2'b10) && !pins_oe && (data_out == '0));

  // R8: underrun is raised only when the queue was empty
  p_underrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(q_empty));
endmodule

bind late_read_driver late_read_driver_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trigger   (trigger),
  .dev_sel_n (dev_sel_n),
  .q_empty   (q_empty),
  .busy      (busy),
  .xcvr_ctl  (xcvr_ctl),
  .pins_oe   (pins_oe),
  .data_out  (data_out),
  .underrun  (underrun)
);

// File: tb/late_read_driver_bench.sv
module late_read_driver_bench;
  localparam int DW = 8;
  localparam int TX = 4;
  localparam int TO = 8;
  localparam int TF = 9;
  localparam int TD = 10;
  localparam int TH = 2;
  localparam int PH = 16;
  localparam int LO = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phi0 = 1'b0;
  logic trigger = 1'b0;
  logic dev_sel_n = 1'b1;
  logic q_empty = 1'b1;
  logic [DW-1:0] q_data = '0;
  logic q_pop, busy, pins_oe, underrun;
  logic [1:0] xcvr_ctl;
  logic [DW-1:0] data_out;

  int n_checks = 0;
  int n_fail = 0;
  logic exp_ur = 1'b0;

  always #2 clk = ~clk;

  late_read_driver #(
    .DATA_W(DW), .T_XCVR(TX), .T_OE(TO), .T_FETCH(TF), .T_DRIVE(TD), .HOLD_CYC(TH)
  ) u_late_read_driver (
    .clk(clk), .rst_n(rst_n), .phi0(phi0), .trigger(trigger), .dev_sel_n(dev_sel_n),
    .q_empty(q_empty), .q_data(q_data), .q_pop(q_pop), .busy(busy),
    .xcvr_ctl(xcvr_ctl), .pins_oe(pins_oe), .data_out(data_out), .underrun(underrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag, input logic e_busy, input logic [1:0] e_x,
                         input logic e_oe, input logic [DW-1:0] e_d, input logic e_ur,
                         input logic e_pop);
    chk({tag, " busy"}, 32'(busy), 32'(e_busy));
    chk({tag, " xcvr"}, 32'(xcvr_ctl), 32'(e_x));
    chk({tag, " oe"}, 32'(pins_oe), 32'(e_oe));
    chk({tag, " data"}, 32'(data_out), 32'(e_d));
    chk({tag, " underrun"}, 32'(underrun), 32'(e_ur));
    chk({tag, " pop"}, 32'(q_pop), 32'(e_pop));
  endtask

  // One bus phase: high for PH clocks, then low for LO clocks
  task automatic run_phase(input bit addr, input bit emp, input logic [DW-1:0] byt,
                           input bit late_trig);
    logic [DW-1:0] fin;
    logic ur_start;
    fin = emp ? '1 : byt;
    ur_start = exp_ur;
    dev_sel_n = addr ? 1'b0 : 1'b1;
    q_empty = emp;
    q_data = byt;
    @(negedge clk) phi0 = 1'b1;
    for (int n = 1; n <= PH; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (!addr) begin
        chk_all("R2 unaddressed", 1'b0, 2'b10, 1'b0, '0, ur_start, 1'b0);
      end else begin
        logic e_ur;
        logic [DW-1:0] e_d;
        if (n < 4) e_ur = ur_start;
        else if (n < TF + 3) e_ur = 1'b0;
        else e_ur = emp;
        if (n < TX + 3) e_d = '0;
        else if (n < TD + 3) e_d = '1;
        else e_d = fin;
        if (n < 4) chk_all("R3 pre-trigger", 1'b0, 2'b10, 1'b0, '0, e_ur, 1'b0);
        else if (n < TX + 3) chk_all("R3 busy", 1'b1, 2'b10, 1'b0, e_d, e_ur, 1'b0);
        else if (n < TO + 3) chk_all("R4 xcvr out", 1'b1, 2'b01, 1'b0, e_d, e_ur, 1'b0);
        else if (n == TF + 2) chk_all("R6 pop", 1'b1, 2'b01, 1'b1, e_d, e_ur, !emp);
        else if (n < TD + 3) chk_all(emp ? "R8 fetch empty" : "R5 oe", 1'b1, 2'b01, 1'b1, e_d, e_ur, 1'b0);
        else chk_all(emp ? "R8 drive ones" : "R7 drive byte", 1'b1, 2'b01, 1'b1, e_d, e_ur, 1'b0);
        exp_ur = e_ur;
      end
      trigger = (n == 3);
    end
    phi0 = 1'b0;
    for (int m = 1; m <= LO; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (addr && m < TH + 4)
        chk_all("R9 hold", 1'b1, 2'b01, 1'b1, fin, exp_ur, 1'b0);
      else if (addr)
        chk_all(late_trig ? "R10 trigger at release" : "R9 released",
                1'b0, 2'b10, 1'b0, '0, exp_ur, 1'b0);
      else
        chk_all("R2 unaddressed low", 1'b0, 2'b10, 1'b0, '0, exp_ur, 1'b0);
      trigger = late_trig && (m == TH + 3);
    end
    trigger = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1 reset", 1'b0, 2'b10, 1'b0, '0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      run_phase((i % 4) != 3, (i % 3) == 1, DW'(i * 53 + 7), (i % 2) == 1);
    end
    // Directed corners: empty after non-empty, byte of all ones, unaddressed after underrun
    run_phase(1'b1, 1'b1, 8'h00, 1'b1);
    run_phase(1'b0, 1'b0, 8'h3C, 1'b0);
    run_phase(1'b1, 1'b0, 8'hFF, 1'b1);
    run_phase(1'b1, 1'b0, 8'h00, 1'b0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule